// File: doc/BRIEF.md
# Matrix LRU Replacement Tracker

This block keeps true least-recently-used order for every set of a k-way set-associative cache. Each set owns a k-by-k bit matrix. Bit (r, c) of that matrix is 1 when way r has been used more recently than way c. When the cache controller reports a hit or a fill, it gives a set index and a way index. In the same clock cycle, the block writes ones across that way's row and zeros down that way's column. The way whose row holds only zeros is then the least recently used one.

Victim lookup is purely combinational from the stored matrices. A query to any set in a given cycle therefore returns that set's victim as it was before any update made at the end of that cycle. The block does not hold tags or data, and it does not decide when an access or an eviction happens.

Top module: `lru_matrix_tracker`

## Requirements
- R1: After reset, every set orders its ways by index. Way 0 is the least recent and way WAYS-1 is the most recent, so every set reports victim 0.
- R2: A touch of way j in set s with `touch_valid` high makes j the most recent way of s. The relative order of the other ways in s is kept.
- R3: `victim_way` is the binary index of the least recent way of set `query_set`. `victim_onehot` has bit w set exactly when w is that way.
- R4: A touch takes effect at the next rising clock edge, so a query in the following cycle already sees it.
- R5: A touch and a query to the same set in the same cycle return the victim from the state before that touch.
- R6: A touch of set s leaves the order of every other set unchanged.
- R7: Out of reset, exactly one bit of `victim_onehot` is set in every cycle.
- R8: Touching the way that is already most recent leaves the order of its set unchanged.
- R9: With `touch_valid` low, no set changes order, whatever values `touch_set` and `touch_way` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| touch_valid | input | 1 | Records an access in this cycle |
| touch_set | input | SET_W | Set that was accessed |
| touch_way | input | WAY_W | Way that was accessed |
| query_set | input | SET_W | Set whose victim is requested |
| victim_way | output | WAY_W | Binary index of the least recent way |
| victim_onehot | output | WAYS | One-hot form of the least recent way |

## Verification
A corrupted matrix bit shows up at the ports in one of two ways. It can produce no all-zero row, which leaves the one-hot victim empty. It can also produce a second all-zero row, which leaves two bits set. Either fault is visible as soon as the affected set is queried. Some wrong bits do not break the single zero row but still reorder the ways. These appear only when enough later touches expose the swapped pair as least recent. For that reason the bench tries every four-touch sequence on one set, and long mixed streams across all sets. After every operation it compares the victim with a recency list kept in the bench.

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker #(
  parameter int WAYS = 4,
  parameter int SETS = 8,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_valid,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] query_set,
  output logic [WAY_W-1:0] victim_way,
  output logic [WAYS-1:0]  victim_onehot
);

  // mat_q[s][r][c] = 1 : way r used more recently than way c in set s
  logic [WAYS-1:0] mat_q [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int r = 0; r < WAYS; r++)
          for (int c = 0; c < WAYS; c++)
            mat_q[s][r][c] <= (c < r);
    end else if (touch_valid) begin
      for (int r = 0; r < WAYS; r++)
        for (int c = 0; c < WAYS; c++)
          if (c == int'(touch_way))
            mat_q[touch_set][r][c] <= 1'b0;
          else if (r == int'(touch_way))
            mat_q[touch_set][r][c] <= 1'b1;
    end
  end

  always_comb begin
    for (int r = 0; r < WAYS; r++)
      victim_onehot[r] = ~|mat_q[query_set][r];
  end

  always_comb begin
    victim_way = '0;
    for (int r = 0; r < WAYS; r++)
      if (victim_onehot[r]) victim_way = WAY_W'(r);
  end

  a_r7_single_victim: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(victim_onehot) == 1);

  a_r1_reset_victim: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> victim_way == '0);

  a_r4_touched_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
    touch_valid |=> (query_set != $past(touch_set)) || (victim_way != $past(touch_way)) || (WAYS == 1));

  a_r9_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!touch_valid || touch_set != query_set) |=> (!$stable(query_set) || $stable(victim_way)));

endmodule

// File: tb/lru_matrix_tracker_bench.sv
module lru_matrix_tracker_bench;
  localparam int WAYS = 4;
  localparam int SETS = 8;
  localparam int WAY_W = 2;
  localparam int SET_W = 3;
  localparam time PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic touch_valid = 0;
  logic [SET_W-1:0] touch_set = '0;
  logic [WAY_W-1:0] touch_way = '0;
  logic [SET_W-1:0] query_set = '0;
  logic [WAY_W-1:0] victim_way;
  logic [WAYS-1:0]  victim_onehot;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int order [SETS][WAYS];   // index 0 = least recent
  int unsigned seed = 32'h1234_5678;

  always #(PERIOD/2) clk = ~clk;

  lru_matrix_tracker #(.WAYS(WAYS), .SETS(SETS)) u_lru_matrix_tracker (
    .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid), .touch_set(touch_set),
    .touch_way(touch_way), .query_set(query_set), .victim_way(victim_way),
    .victim_onehot(victim_onehot));

  task automatic ref_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) order[s][w] = w;
  endtask

  task automatic ref_touch(int s, int w);
    int pos = 0;
    for (int i = 0; i < WAYS; i++) if (order[s][i] == w) pos = i;
    for (int i = pos; i < WAYS-1; i++) order[s][i] = order[s][i+1];
    order[s][WAYS-1] = w;
  endtask

  task automatic op(bit v, int s, int w, int q, string tag);
    int exp_w;
    logic [WAYS-1:0] exp_oh;
    @(negedge clk);
    touch_valid = v; touch_set = SET_W'(s); touch_way = WAY_W'(w); query_set = SET_W'(q);
    #1;
    exp_w = order[q][0];
    exp_oh = WAYS'(1) << exp_w;
    checks++;
    if (int'(victim_way) != exp_w) begin
      errors++;
      $display("FAIL %s victim_way set %0d: actual %0d expected %0d", tag, q, victim_way, exp_w);
    end
    checks++;
    if (victim_onehot !== exp_oh) begin
      errors++;
      $display("FAIL %s/R7 victim_onehot set %0d: actual %b expected %b", tag, q, victim_onehot, exp_oh);
    end
    @(posedge clk);
    if (v) ref_touch(s, w);
  endtask

  function automatic int rnd(int m);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'((seed >> 8) % m);
  endfunction

  initial begin
    ref_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    for (int s = 0; s < SETS; s++) op(0, 0, 0, s, "R1");

    // exhaustive 4-touch sequences on set 3, query same set (R2 R3 R4 R5 R8)
    for (int seq = 0; seq < 256; seq++)
      for (int k = 0; k < 4; k++)
        op(1, 3, (seq >> (2*k)) & 3, 3, "R2_R3_R4_R5");

    // repeated touch of the most recent way (R8)
    for (int s = 0; s < SETS; s++) begin
      op(1, s, 2, s, "R8");
      op(1, s, 2, s, "R8");
      op(0, 0, 0, s, "R8");
    end

    // cross-set isolation (R6)
    for (int s = 0; s < SETS; s++) begin
      op(1, s, 0, (s+1) % SETS, "R6");
      op(0, 0, 0, (s+1) % SETS, "R6");
    end

    // touch_valid low with arbitrary fields (R9)
    for (int i = 0; i < 64; i++) op(0, i % SETS, i % WAYS, (i*3) % SETS, "R9");

    // mixed stream across all sets (R3 R4 R5 R6)
    for (int i = 0; i < 4000; i++) begin
      int s = rnd(SETS);
      op(rnd(4) != 0, s, rnd(WAYS), (rnd(2) != 0) ? s : rnd(SETS), "R3_R6");
    end

    // reset again restores index ordering (R1)
    @(negedge clk) rst_n = 0;
    ref_reset();
    @(negedge clk) rst_n = 1;
    for (int s = 0; s < SETS; s++) op(0, 0, 0, s, "R1");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule